// File: doc/BRIEF.md
# Processor Status and Stack Unit

This unit keeps the seven condition flags and the stack pointer of a small 8-bit accumulator processor. It packs the flags into a status byte for the rest of the core. It also turns stack commands into single-byte memory accesses on a fixed stack page. The commands are: push or pull a byte, push or pull a 16-bit word, push or pull the status, and a soft reset. Decode logic issues one command at a time through `cmd_valid`/`cmd` while `busy` is low. The unit then drives a one-byte-per-clock memory port whose read data is returned in the same cycle.

A word operation takes two back-to-back memory cycles and holds `busy` for both. Any command that arrives while `busy` is high is dropped. When a pull finishes, the assembled data appears on `pull_data` together with a one-cycle `pull_valid` pulse.

Top module: `pstack_unit`

## Requirements
- R1: Asynchronous reset (`rst_n` low), or command code 7 accepted while idle, sets the stack pointer to 0xFD, sets I and clears C, Z, D, B, V and N, so `status_byte` reads 0x24. The soft reset takes effect at the accepting edge and raises no `busy`.
- R2: `status_byte` bit positions are, from bit 7 to bit 0: N, V, constant one, B, D, I, Z, C. Bit 5 is always one.
- R3: Push byte (code 1) writes `data_in[7:0]` to address 0x0100 | SP and then decrements SP by one.
- R4: Pull byte (code 3) first increments SP, then reads address 0x0100 | (new SP). It returns the byte in `pull_data[7:0]` with the upper bits zero.
- R5: Every memory access uses the stack page: `mem_addr[15:8]` is 0x01 whenever `mem_req` is high.
- R6: Push word (code 2) writes `data_in[15:8]` at SP and then `data_in[7:0]` at SP-1, in two consecutive cycles. SP ends lowered by two.
- R7: Pull word (code 4) reads the low byte at SP+1 and then the high byte at SP+2, in two consecutive cycles. It returns {high, low} on `pull_data`, and SP ends raised by two.
- R8: Push status (code 5) writes the status byte with bit 4 (B) forced to one and bit 5 one. The internal B flag is unchanged.
- R9: Pull status (code 6) loads C, Z, I, D, V and N from bits 0, 1, 2, 3, 6 and 7 of the pulled byte. B and the constant bit keep their values whatever bits 4 and 5 of the byte are.
- R10: SP wraps modulo 256 in both directions, with no error indication.
- R11: `busy` is high for one cycle per memory access, starting the cycle after a command is accepted: one cycle for byte and status commands, two for word commands. A command presented while `busy` is high is ignored. `mem_req` is never high while `busy` is low.
- R12: `pull_valid` is high for exactly the one cycle after the final read of a pull command. Code 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd | input | 3 | Command code (0 no-op, 1..6 stack commands, 7 soft reset) |
| data_in | input | 16 | Data for push byte (low 8 bits) or push word |
| mem_req | output | 1 | Memory access strobe, one byte per cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Stack address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the request |
| busy | output | 1 | Command in progress |
| pull_valid | output | 1 | One-cycle pulse: `pull_data` updated |
| pull_data | output | 16 | Result of the last pull |
| status_byte | output | 8 | Packed flags |
| sp | output | 8 | Stack pointer |

## Verification
On every cycle, the assertions check the following. Accesses stay on the stack page. SP moves by exactly one around each write and read, in the correct direction relative to the address used. The second write of a word lands one byte below the first. A pushed status byte carries B and the constant bit. B survives a status load, and memory strobes occur only while busy. The bench scenarios cover the rest. They sweep all 256 pushes and pulls around the full SP wrap, and all 256 pulled status values each followed by a push. They also check the byte order of word transfers, the length of `busy`, a command dropped while busy, and the soft reset.

// File: rtl/pstack_pkg.sv
package pstack_pkg;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_PUSH_BYTE = 3'd1,
        CMD_PUSH_WORD = 3'd2,
        CMD_PULL_BYTE = 3'd3,
        CMD_PULL_WORD = 3'd4,
        CMD_PUSH_STAT = 3'd5,
        CMD_PULL_STAT = 3'd6,
        CMD_SOFT_RST  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic n;
        logic v;
        logic b;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_AT_RESET = '{n: 1'b0, v: 1'b0, b: 1'b0, d: 1'b0,
                                          i: 1'b1, z: 1'b0, c: 1'b0};

endpackage

// File: rtl/pstack_pack.sv
module pstack_pack
    import pstack_pkg::*;
#(
    parameter bit FORCE_BRK = 1'b0
) (
    input  flags_t     flags,
    output logic [7:0] packed_byte
);
    always_comb begin
        packed_byte = {flags.n, flags.v, 1'b1, (flags.b | FORCE_BRK),
                       flags.d, flags.i, flags.z, flags.c};
    end
endmodule

// File: rtl/pstack_flags.sv
module pstack_flags
    import pstack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       load_en,
    input  logic [7:0] load_byte,
    output flags_t     flags
);
    flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (soft_rst) begin
            flags_d = FLAGS_AT_RESET;
        end else if (load_en) begin
            flags_d.c = load_byte[0];
            flags_d.z = load_byte[1];
            flags_d.i = load_byte[2];
            flags_d.d = load_byte[3];
            flags_d.v = load_byte[6];
            flags_d.n = load_byte[7];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= FLAGS_AT_RESET;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    // R9: a status load never alters the break flag
    a_r9_brk_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !soft_rst) |=> (flags_q.b == $past(flags_q.b)));

endmodule

// File: rtl/pstack_seq.sv
module pstack_seq
    import pstack_pkg::*;
#(
    parameter int                     DATA_W  = 8,
    parameter int                     ADDR_W  = 16,
    parameter logic [ADDR_W-DATA_W-1:0] PAGE  = 'h01,
    parameter logic [DATA_W-1:0]      SP_INIT = 'hFD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd,
    input  logic [2*DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0]   stat_push,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                busy,
    output logic                soft_rst,
    output logic                load_en,
    output logic [DATA_W-1:0]   load_byte,
    output logic                pull_valid,
    output logic [2*DATA_W-1:0] pull_data,
    output logic [DATA_W-1:0]   sp
);
    typedef struct packed {
        seq_st_e              st;
        cmd_e                 op;
        logic [2*DATA_W-1:0]  data;
        logic [DATA_W-1:0]    sp;
        logic [DATA_W-1:0]    lo;
        logic                 pv;
        logic [2*DATA_W-1:0]  pdata;
    } seq_t;

    seq_t s_d, s_q;
    logic [DATA_W-1:0] sp_inc, sp_dec;
    logic              is_push;
    cmd_e              cmd_in;

    always_comb begin
        cmd_in    = cmd_e'(cmd);
        sp_inc    = s_q.sp + 1'b1;
        sp_dec    = s_q.sp - 1'b1;
        is_push   = (s_q.op == CMD_PUSH_BYTE) || (s_q.op == CMD_PUSH_WORD) ||
                    (s_q.op == CMD_PUSH_STAT);
        s_d       = s_q;
        s_d.pv    = 1'b0;
        soft_rst  = 1'b0;
        load_en   = 1'b0;
        load_byte = mem_rdata;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {PAGE, s_q.sp};
        mem_wdata = '0;
        case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_in == CMD_SOFT_RST) begin
                        s_d.sp   = SP_INIT;
                        soft_rst = 1'b1;
                    end else if (cmd_in != CMD_NONE) begin
                        s_d.st   = ST_FIRST;
                        s_d.op   = cmd_in;
                        s_d.data = data_in;
                    end
                end
            end
            ST_FIRST: begin
                mem_req = 1'b1;
                if (is_push) begin
                    mem_we   = 1'b1;
                    mem_addr = {PAGE, s_q.sp};
                    if (s_q.op == CMD_PUSH_WORD)      mem_wdata = s_q.data[2*DATA_W-1:DATA_W];
                    else if (s_q.op == CMD_PUSH_STAT) mem_wdata = stat_push;
                    else                              mem_wdata = s_q.data[DATA_W-1:0];
                    s_d.sp = sp_dec;
                    s_d.st = (s_q.op == CMD_PUSH_WORD) ? ST_SECOND : ST_IDLE;
                end else begin
                    mem_addr = {PAGE, sp_inc};
                    s_d.sp   = sp_inc;
                    if (s_q.op == CMD_PULL_WORD) begin
                        s_d.lo = mem_rdata;
                        s_d.st = ST_SECOND;
                    end else begin
                        s_d.st    = ST_IDLE;
                        s_d.pv    = 1'b1;
                        s_d.pdata = {{DATA_W{1'b0}}, mem_rdata};
                        load_en   = (s_q.op == CMD_PULL_STAT);
                    end
                end
            end
            ST_SECOND: begin
                mem_req = 1'b1;
                if (s_q.op == CMD_PUSH_WORD) begin
                    mem_we    = 1'b1;
                    mem_addr  = {PAGE, s_q.sp};
                    mem_wdata = s_q.data[DATA_W-1:0];
                    s_d.sp    = sp_dec;
                end else begin
                    mem_addr  = {PAGE, sp_inc};
                    s_d.sp    = sp_inc;
                    s_d.pv    = 1'b1;
                    s_d.pdata = {mem_rdata, s_q.lo};
                end
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.op    <= CMD_NONE;
            s_q.sp    <= SP_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign pull_valid = s_q.pv;
    assign pull_data  = s_q.pdata;
    assign sp         = s_q.sp;

    // R5: accesses stay on the stack page
    a_r5_page: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ADDR_W-1:DATA_W] == PAGE));

    // R3: after a write, SP sits one below the written address
    a_r3_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (sp == $past(mem_addr[DATA_W-1:0]) - 1'b1));

    // R4: after a read, SP equals the address just read
    a_r4_pull_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (sp == $past(mem_addr[DATA_W-1:0])));

    // R6: second word write lands one byte below the first
    a_r6_word_order: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_FIRST && s_q.op == CMD_PUSH_WORD) |=>
        (mem_req && mem_we && mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) - 1'b1));

    // R8: pushed status carries the break bit and the constant bit
    a_r8_stat_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && s_q.op == CMD_PUSH_STAT) |-> (mem_wdata[5] && mem_wdata[4]));

    // R11: no memory strobe outside a busy command
    a_r11_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R12: pull_valid is a single-cycle pulse
    a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pull_valid |=> !pull_valid);

endmodule

// File: rtl/pstack_unit.sv
module pstack_unit
    import pstack_pkg::*;
#(
    parameter int                       DATA_W  = 8,
    parameter int                       ADDR_W  = 16,
    parameter logic [ADDR_W-DATA_W-1:0] PAGE    = 'h01,
    parameter logic [DATA_W-1:0]        SP_INIT = 'hFD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd,
    input  logic [2*DATA_W-1:0] data_in,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                pull_valid,
    output logic [2*DATA_W-1:0] pull_data,
    output logic [7:0]          status_byte,
    output logic [DATA_W-1:0]   sp
);
    flags_t     flags;
    logic       soft_rst, load_en;
    logic [7:0] load_byte;
    logic [7:0] packed_v [2];

    for (genvar g = 0; g < 2; g++) begin : g_pack
        pstack_pack #(.FORCE_BRK(g == 1)) u_pack (
            .flags       (flags),
            .packed_byte (packed_v[g])
        );
    end

    pstack_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .load_en   (load_en),
        .load_byte (load_byte),
        .flags     (flags)
    );

    pstack_seq #(
        .DATA_W (DATA_W), .ADDR_W (ADDR_W), .PAGE (PAGE), .SP_INIT (SP_INIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .data_in    (data_in),
        .stat_push  (packed_v[1]),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .soft_rst   (soft_rst),
        .load_en    (load_en),
        .load_byte  (load_byte),
        .pull_valid (pull_valid),
        .pull_data  (pull_data),
        .sp         (sp)
    );

    assign status_byte = packed_v[0];

endmodule

// File: tb/tb_pstack_unit.sv
module tb_pstack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [15:0] data_in = 16'h0;
    logic        mem_req, mem_we, busy, pull_valid;
    logic [15:0] mem_addr, pull_data;
    logic [7:0]  mem_wdata, mem_rdata, status_byte, sp;

    logic [7:0]  smem [256];
    int          errors = 0, checks = 0, busy_cycles = 0;
    logic [7:0]  exp_sp;

    always #5 clk = ~clk;

    pstack_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .data_in(data_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .pull_valid(pull_valid), .pull_data(pull_data),
        .status_byte(status_byte), .sp(sp)
    );

    assign mem_rdata = smem[mem_addr[7:0]];
    always @(posedge clk) if (mem_req && mem_we) smem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] c, input logic [15:0] d);
        @(negedge clk); cmd_valid = 1'b1; cmd = c; data_in = d;
        @(negedge clk); cmd_valid = 1'b0;
        busy_cycles = 0;
        while (busy) begin busy_cycles++; @(negedge clk); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) smem[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp == 8'hFD, "R1 reset sp", sp, 8'hFD);
        chk(status_byte == 8'h24, "R1 reset status", status_byte, 8'h24);
        chk(!busy && !mem_req, "R11 idle after reset", busy, 0);
        exp_sp = 8'hFD;

        // R12: no-op command leaves everything alone
        run(3'd0, 16'h0);
        chk(sp == exp_sp && busy_cycles == 0, "R12 no-op", sp, exp_sp);

        // R3, R10: 256 pushes around the full wrap
        for (int v = 0; v < 256; v++) begin
            run(3'd1, {8'hEE, 8'(v)});
            chk(smem[exp_sp] == 8'(v), "R3 push byte data", smem[exp_sp], v);
            exp_sp = exp_sp - 8'd1;
            chk(sp == exp_sp, "R10 push sp wrap", sp, exp_sp);
            chk(busy_cycles == 1, "R11 byte busy length", busy_cycles, 1);
        end
        // R4, R10, R12: 256 pulls back, LIFO order
        for (int v = 255; v >= 0; v--) begin
            run(3'd3, 16'h0);
            exp_sp = exp_sp + 8'd1;
            chk(pull_valid && pull_data == 16'(v), "R4 pull byte data", pull_data, v);
            chk(sp == exp_sp, "R10 pull sp wrap", sp, exp_sp);
        end
        @(negedge clk);
        chk(!pull_valid, "R12 pulse one cycle", pull_valid, 0);

        // R6: push word high then low
        run(3'd2, 16'hA55A);
        chk(smem[exp_sp] == 8'hA5, "R6 word high first", smem[exp_sp], 8'hA5);
        chk(smem[8'(exp_sp - 8'd1)] == 8'h5A, "R6 word low second", smem[8'(exp_sp - 8'd1)], 8'h5A);
        exp_sp = exp_sp - 8'd2;
        chk(sp == exp_sp, "R6 word sp", sp, exp_sp);
        chk(busy_cycles == 2, "R11 word busy length", busy_cycles, 2);
        // R7: pull word low then high
        run(3'd4, 16'h0);
        exp_sp = exp_sp + 8'd2;
        chk(pull_valid && pull_data == 16'hA55A, "R7 pull word", pull_data, 16'hA55A);
        chk(sp == exp_sp && busy_cycles == 2, "R7 word sp", sp, exp_sp);
        // R7, R10: pull word across the wrap from FD: reads FE,FF then 00,01
        smem[8'hFE] = 8'h34; smem[8'hFF] = 8'h12; smem[8'h00] = 8'h78; smem[8'h01] = 8'h56;
        run(3'd4, 16'h0);
        run(3'd4, 16'h0);
        chk(pull_data == 16'h5678, "R7 word over wrap", pull_data, 16'h5678);
        chk(sp == 8'h01, "R10 word wrap sp", sp, 8'h01);
        exp_sp = 8'h01;

        // R2, R8, R9: every pulled status value, then pushed back
        for (int b = 0; b < 256; b++) begin
            logic [7:0] es;
            smem[8'(exp_sp + 8'd1)] = 8'(b);
            run(3'd6, 16'h0);
            exp_sp = exp_sp + 8'd1;
            es = (8'(b) | 8'h20) & 8'hEF;
            chk(status_byte == es, "R9 pull status", status_byte, es);
            chk(status_byte[5], "R2 constant bit", status_byte, es);
            run(3'd5, 16'h0);
            chk(smem[exp_sp] == (es | 8'h10), "R8 pushed status", smem[exp_sp], es | 8'h10);
            chk(status_byte[4] == 1'b0, "R8 internal B unchanged", status_byte, es);
            exp_sp = exp_sp - 8'd1;
        end
        chk(sp == exp_sp, "R9 status sweep sp", sp, exp_sp);

        // R11: command while busy is dropped
        @(negedge clk); cmd_valid = 1'b1; cmd = 3'd2; data_in = 16'hBEEF;
        @(negedge clk); cmd = 3'd3;
        @(negedge clk);
        @(negedge clk); cmd_valid = 1'b0;
        chk(!busy, "R11 idle after word", busy, 0);
        chk(sp == 8'(exp_sp - 8'd2), "R11 busy command ignored", sp, 8'(exp_sp - 8'd2));
        chk(smem[8'(exp_sp - 8'd1)] == 8'hEF, "R11 word intact", smem[8'(exp_sp - 8'd1)], 8'hEF);

        // R1: soft reset command
        run(3'd7, 16'h0);
        chk(busy_cycles == 0, "R1 soft reset no busy", busy_cycles, 0);
        chk(sp == 8'hFD, "R1 soft reset sp", sp, 8'hFD);
        chk(status_byte == 8'h24, "R1 soft reset status", status_byte, 8'h24);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule